// File: doc/BRIEF.md
# Watermark-Paced Single-Block Data Mover

This block moves exactly one 512-byte data block between a host-side stream of 32-bit words and the data buffer of a card controller. It first asks an external command engine to issue the single-block read or write command. For a standard-capacity card the command argument is the byte address, and for a high-capacity card it is the sector number itself. Once that command is accepted, the block is moved in bursts of one FIFO watermark, 16 words each, and 8 bursts make up a block. A burst starts only when the controller reports that a full watermark can be read, or that one can be written.

Before every burst the mover looks at the three data error flags. If any of them is set, the mover pulses a clear for those flags. It then keeps asking the command engine for a stop command while the data line reports activity, up to a fixed number of attempts. The outcome is reported as an error code, or as a no-response code if the attempts run out. After the last burst the mover waits for the controller's transfer-complete indication. It then pulses a clear for the completion flags and reports success. A request made while the card is not ready is refused in the next cycle and touches nothing.

Top module: `sdm_block_mover`

## Requirements
- R1: After reset, busy, done, cmd_valid, fifo_rd, fifo_wr, err_clr and fin_clr are 0, and result is 0.
- R2: A start while idle with card_ready low gives a one-cycle done on the next clock with result 3 (not ready). No command is issued and no word moves.
- R3: A start with card_ready high holds cmd_valid until cmd_done. The kind is 0 for read and 1 for write. cmd_arg is sector shifted left by 9 when high_cap is 0, and sector itself when high_cap is 1. A stop command has kind 2 and argument 0.
- R4: If the data command completes with cmd_ok low, done follows with result 1 (error) and no word moves.
- R5: In a read, 128 words pass from fifo_rdata to host_out_data in order. A word is popped (fifo_rd) only in a cycle where host_out_valid and host_out_ready are both high.
- R6: In a write, 128 words pass from host_in_data to fifo_wdata in order. A word is pushed (fifo_wr) only in a cycle where host_in_valid and host_in_ready are both high.
- R7: Each burst is exactly 16 words. It starts only after buf_rd_rdy (read) or buf_wr_rdy (write) is seen high while waiting, and no word moves while the mover is waiting for that flag.
- R8: The three error inputs are checked before each burst, and they take priority over the buffer flag. If any of them is set, err_clr pulses for one cycle, no word of that burst moves, and a stop command follows.
- R9: The stop command is reissued while line_active is high and cmd_ok is high. When a stop completes with line_active low, or with cmd_ok low, done follows with result 1.
- R10: If line_active is still high after 100 stop commands, done follows with result 5 (no response), and no more stops are issued.
- R11: After the last word of the last burst the mover waits for xfer_done. One clock after xfer_done is sampled, done and fin_clr pulse together with result 0.
- R12: The word and burst counts restart at every block, so a block that follows an aborted one again moves a full 128 words in 8 bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one block transfer (sampled while idle) |
| dir_write | input | 1 | 1 = write to card, 0 = read from card |
| sector | input | 32 | Sector number of the block |
| card_ready | input | 1 | Card has been initialised |
| high_cap | input | 1 | Card addresses by sector rather than by byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 error, 3 not ready, 5 no response |
| cmd_valid | output | 1 | Command request to the command engine |
| cmd_kind | output | 2 | 0 read block, 1 write block, 2 stop |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command engine finished the current command |
| cmd_ok | input | 1 | Command finished without error (with cmd_done) |
| buf_rd_rdy | input | 1 | A full watermark can be read from the buffer |
| buf_wr_rdy | input | 1 | A full watermark can be written to the buffer |
| fifo_rdata | input | 32 | Word at the head of the read buffer |
| fifo_rd | output | 1 | Pop one word from the read buffer |
| fifo_wdata | output | 32 | Word pushed into the write buffer |
| fifo_wr | output | 1 | Push one word into the write buffer |
| host_out_data | output | 32 | Read word towards the host |
| host_out_valid | output | 1 | host_out_data is valid |
| host_out_ready | input | 1 | Host accepts the read word |
| host_in_data | input | 32 | Write word from the host |
| host_in_valid | input | 1 | host_in_data is valid |
| host_in_ready | output | 1 | Mover accepts the write word |
| err_endbit | input | 1 | Data end-bit error flag |
| err_crc | input | 1 | Data CRC error flag |
| err_tmo | input | 1 | Data timeout flag |
| err_clr | output | 1 | Pulse clearing the three data error flags |
| line_active | input | 1 | Data line still active |
| xfer_done | input | 1 | Controller reports transfer complete |
| fin_clr | output | 1 | Pulse clearing the completion, buffer-ready and auto-stop error flags |

## Verification
Every registered result is due exactly one clock after the edge that samples its cause. done with result 3 follows the start edge. done with fin_clr follows the edge that sees xfer_done. err_clr and the stop request follow the edge that sees an error flag in the waiting state. The word handshakes (fifo_rd, fifo_wr) are combinational in the current cycle. The bench drives inputs one time unit after a clock edge and samples every output at the falling edge, which lies between that drive and the edge that commits it. Each expected count is therefore read in the half cycle where it has become valid. Buffer flags are raised only after a fixed wait, so a word that moves too early, or a burst that is too long or too short, shows up as a wrong count at a known falling edge.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_MOVE,
        ST_TC,
        ST_STOP
    } state_t;

    typedef logic [2:0] res_t;

    localparam res_t RES_OK        = 3'd0;
    localparam res_t RES_ERROR     = 3'd1;
    localparam res_t RES_NOT_READY = 3'd3;
    localparam res_t RES_NO_RESP   = 3'd5;

    localparam logic [1:0] KIND_RD   = 2'd0;
    localparam logic [1:0] KIND_WR   = 2'd1;
    localparam logic [1:0] KIND_STOP = 2'd2;

endpackage

// File: rtl/sdm_addr.sv
module sdm_addr #(
    parameter int AW          = 32,
    parameter int BLOCK_BYTES = 512
) (
    input  logic          high_cap,
    input  logic [AW-1:0] sector,
    output logic [AW-1:0] arg
);
    localparam int SHIFT = $clog2(BLOCK_BYTES);

    // byte addressing for standard cards, sector addressing otherwise
    always_comb begin
        if (high_cap) arg = sector;
        else          arg = sector << SHIFT;
    end
endmodule

// File: rtl/sdm_pace.sv
module sdm_pace #(
    parameter int WORDS  = 16,
    parameter int BURSTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last_word,
    output logic last_burst
);
    localparam int WW = (WORDS  > 1) ? $clog2(WORDS)  : 1;
    localparam int BW = (BURSTS > 1) ? $clog2(BURSTS) : 1;

    typedef struct packed {
        logic [WW-1:0] word;
        logic [BW-1:0] burst;
    } pace_t;

    pace_t d, q;

    assign last_word  = (q.word  == WW'(WORDS - 1));
    assign last_burst = (q.burst == BW'(BURSTS - 1));

    always_comb begin
        d = q;
        if (clear) begin
            d.word  = '0;
            d.burst = '0;
        end else if (step) begin
            if (last_word) begin
                d.word  = '0;
                d.burst = q.burst + 1'b1;
            end else begin
                d.word  = q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last_word) |=> (q.word == '0));

endmodule

// File: rtl/sdm_retry.sv
module sdm_retry #(
    parameter int TRIES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CW = $clog2(TRIES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } retry_t;

    retry_t d, q;

    assign last_try = (q.cnt == CW'(TRIES - 1));

    always_comb begin
        d = q;
        if (clear)                 d.cnt = '0;
        else if (bump && !last_try) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10
    retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(TRIES));

endmodule

// File: rtl/sdm_block_mover.sv
module sdm_block_mover
    import sdm_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int BLOCK_BYTES = 512,
    parameter int WATERMARK   = 16,
    parameter int STOP_TRIES  = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_write,
    input  logic [AW-1:0] sector,
    input  logic          card_ready,
    input  logic          high_cap,
    output logic          busy,
    output logic          done,
    output logic [2:0]    result,
    output logic          cmd_valid,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_arg,
    input  logic          cmd_done,
    input  logic          cmd_ok,
    input  logic          buf_rd_rdy,
    input  logic          buf_wr_rdy,
    input  logic [DW-1:0] fifo_rdata,
    output logic          fifo_rd,
    output logic [DW-1:0] fifo_wdata,
    output logic          fifo_wr,
    output logic [DW-1:0] host_out_data,
    output logic          host_out_valid,
    input  logic          host_out_ready,
    input  logic [DW-1:0] host_in_data,
    input  logic          host_in_valid,
    output logic          host_in_ready,
    input  logic          err_endbit,
    input  logic          err_crc,
    input  logic          err_tmo,
    output logic          err_clr,
    input  logic          line_active,
    input  logic          xfer_done,
    output logic          fin_clr
);
    localparam int BURSTS = BLOCK_BYTES / ((DW / 8) * WATERMARK);

    typedef struct packed {
        state_t        state;
        logic          wr;
        logic [AW-1:0] arg;
        logic          done;
        res_t          result;
        logic          err_clr;
        logic          fin_clr;
    } ctl_t;

    ctl_t d, q;

    logic [AW-1:0] addr_arg;
    logic          pace_clear, step, last_word, last_burst;
    logic          retry_clear, retry_bump, last_try;
    logic          word_fire, any_err, buf_ok;

    sdm_addr #(.AW(AW), .BLOCK_BYTES(BLOCK_BYTES)) u_addr (
        .high_cap (high_cap),
        .sector   (sector),
        .arg      (addr_arg)
    );

    sdm_pace #(.WORDS(WATERMARK), .BURSTS(BURSTS)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pace_clear),
        .step       (step),
        .last_word  (last_word),
        .last_burst (last_burst)
    );

    sdm_retry #(.TRIES(STOP_TRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (retry_clear),
        .bump     (retry_bump),
        .last_try (last_try)
    );

    // word handshakes towards host and buffer
    assign host_out_valid = (q.state == ST_MOVE) && !q.wr;
    assign host_in_ready  = (q.state == ST_MOVE) &&  q.wr;
    assign host_out_data  = fifo_rdata;
    assign fifo_wdata     = host_in_data;
    assign fifo_rd        = host_out_valid && host_out_ready;
    assign fifo_wr        = host_in_ready  && host_in_valid;
    assign word_fire      = fifo_rd || fifo_wr;
    assign step           = word_fire;

    assign any_err = err_endbit || err_crc || err_tmo;
    assign buf_ok  = q.wr ? buf_wr_rdy : buf_rd_rdy;

    // command request
    assign cmd_valid = (q.state == ST_CMD) || (q.state == ST_STOP);
    assign cmd_kind  = (q.state == ST_STOP) ? KIND_STOP : (q.wr ? KIND_WR : KIND_RD);
    assign cmd_arg   = (q.state == ST_STOP) ? '0 : q.arg;

    assign busy    = (q.state != ST_IDLE);
    assign done    = q.done;
    assign result  = q.result;
    assign err_clr = q.err_clr;
    assign fin_clr = q.fin_clr;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.err_clr   = 1'b0;
        d.fin_clr   = 1'b0;
        pace_clear  = 1'b0;
        retry_clear = 1'b0;
        retry_bump  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (!card_ready) begin
                        d.done   = 1'b1;
                        d.result = RES_NOT_READY;
                    end else begin
                        d.state    = ST_CMD;
                        d.wr       = dir_write;
                        d.arg      = addr_arg;
                        pace_clear = 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_done) begin
                    if (cmd_ok) begin
                        d.state = ST_WAIT;
                    end else begin
                        d.state  = ST_IDLE;
                        d.done   = 1'b1;
                        d.result = RES_ERROR;
                    end
                end
            end
            ST_WAIT: begin
                // error flags win over the buffer flag
                if (any_err) begin
                    d.state     = ST_STOP;
                    d.err_clr   = 1'b1;
                    retry_clear = 1'b1;
                end else if (buf_ok) begin
                    d.state = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (word_fire && last_word)
                    d.state = last_burst ? ST_TC : ST_WAIT;
            end
            ST_TC: begin
                if (xfer_done) begin
                    d.state   = ST_IDLE;
                    d.done    = 1'b1;
                    d.result  = RES_OK;
                    d.fin_clr = 1'b1;
                end
            end
            ST_STOP: begin
                if (cmd_done) begin
                    retry_bump = 1'b1;
                    if (!cmd_ok || !line_active) begin
                        d.state  = ST_IDLE;
                        d.done   = 1'b1;
                        d.result = RES_ERROR;
                    end else if (last_try) begin
                        d.state  = ST_IDLE;
                        d.done   = 1'b1;
                        d.result = RES_NO_RESP;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.result  <= RES_OK;
        end else begin
            q <= d;
        end
    end

    // R2
    not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !card_ready) |=> (done && result == RES_NOT_READY));

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_arg) && $stable(cmd_kind)));

    // R8
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |-> (cmd_valid && cmd_kind == KIND_STOP));

    // R11
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_TC && xfer_done) |=> (done && fin_clr && !busy));

endmodule

// File: tb/tb_sdm_block_mover.sv
module tb_sdm_block_mover;
    localparam int WORDS      = 16;
    localparam int BURSTS     = 8;
    localparam int STOP_TRIES = 100;
    localparam logic [31:0] RD_BASE = 32'hC0DE_0000;
    localparam logic [31:0] WR_BASE = 32'h5EED_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_write = 1'b0, card_ready = 1'b0, high_cap = 1'b0;
    logic [31:0] sector = '0;
    logic        busy, done, cmd_valid, fifo_rd, fifo_wr, host_out_valid, host_in_ready;
    logic        err_clr, fin_clr;
    logic [2:0]  result;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_arg, fifo_rdata, fifo_wdata, host_out_data, host_in_data;
    logic        cmd_done = 1'b0, cmd_ok = 1'b1;
    logic        buf_rd_rdy = 1'b0, buf_wr_rdy = 1'b0;
    logic        host_out_ready = 1'b0, host_in_valid = 1'b0;
    logic        err_endbit = 1'b0, err_crc = 1'b0, err_tmo = 1'b0;
    logic        line_active = 1'b0, xfer_done = 1'b0;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    int rxcnt = 0, wcnt = 0, stops = 0, datacmds = 0, errclr_cnt = 0;
    int done_cnt = 0, fin_cnt = 0, line_limit = 0, cyc = 0;
    logic [31:0] last_arg = '0;
    logic [1:0]  last_kind = '0;
    logic [2:0]  last_result = '0;

    always #4 clk = ~clk;

    assign fifo_rdata   = RD_BASE + 32'(rxcnt);
    assign host_in_data = WR_BASE + 32'(wcnt);

    sdm_block_mover dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write), .sector(sector),
        .card_ready(card_ready), .high_cap(high_cap), .busy(busy), .done(done),
        .result(result), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_arg(cmd_arg),
        .cmd_done(cmd_done), .cmd_ok(cmd_ok), .buf_rd_rdy(buf_rd_rdy), .buf_wr_rdy(buf_wr_rdy),
        .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .fifo_wdata(fifo_wdata), .fifo_wr(fifo_wr),
        .host_out_data(host_out_data), .host_out_valid(host_out_valid),
        .host_out_ready(host_out_ready), .host_in_data(host_in_data),
        .host_in_valid(host_in_valid), .host_in_ready(host_in_ready),
        .err_endbit(err_endbit), .err_crc(err_crc), .err_tmo(err_tmo), .err_clr(err_clr),
        .line_active(line_active), .xfer_done(xfer_done), .fin_clr(fin_clr)
    );

    // host pacing and command engine model, driven just after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        host_out_ready = (cyc % 3) != 1;
        host_in_valid  = (cyc % 4) != 2;
        cmd_done       = cmd_valid && !cmd_done;
    end

    // observer at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_rd) begin
                mon_checks++;
                if (host_out_data !== RD_BASE + 32'(rxcnt)) begin
                    mon_fails++;
                    $display("FAIL R5 read word %0d: got %h expected %h", rxcnt, host_out_data, RD_BASE + 32'(rxcnt));
                end
                rxcnt++;
            end
            if (fifo_wr) begin
                mon_checks++;
                if (fifo_wdata !== WR_BASE + 32'(wcnt)) begin
                    mon_fails++;
                    $display("FAIL R6 write word %0d: got %h expected %h", wcnt, fifo_wdata, WR_BASE + 32'(wcnt));
                end
                wcnt++;
            end
            if (cmd_valid && cmd_done) begin
                if (cmd_kind == 2'd2) begin
                    stops++;
                    mon_checks++;
                    if (cmd_arg !== 32'd0) begin
                        mon_fails++;
                        $display("FAIL R3 stop argument: got %h expected 0", cmd_arg);
                    end
                end else begin
                    datacmds++;
                    last_arg  = cmd_arg;
                    last_kind = cmd_kind;
                end
            end
            if (err_clr) errclr_cnt++;
            if (done) begin
                done_cnt++;
                last_result = result;
                if (fin_clr) fin_cnt++;
            end
        end
        line_active = (stops < line_limit);
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic nclk();
        @(negedge clk);
        #1;
    endtask

    function automatic int moved(input bit wr);
        return wr ? wcnt : rxcnt;
    endfunction

    task automatic wait_done(input int dn0);
        int t = 0;
        while (done_cnt == dn0 && t < 2000) begin
            nclk();
            t++;
        end
    endtask

    task automatic test_reset();
        check(busy == 0 && done == 0 && result == 0, "R1", "busy/done/result after reset", {busy, done, result}, 0);
        check(cmd_valid == 0 && fifo_rd == 0 && fifo_wr == 0 && err_clr == 0 && fin_clr == 0,
              "R1", "strobes after reset", {cmd_valid, fifo_rd, fifo_wr, err_clr, fin_clr}, 0);
    endtask

    task automatic test_not_ready();
        int dn0 = done_cnt, d0 = datacmds, r0 = rxcnt;
        card_ready = 1'b0;
        dir_write  = 1'b0;
        start      = 1'b1;
        nclk();
        start = 1'b0;
        check(done_cnt == dn0 + 1, "R2", "done one clock after refused start", done_cnt - dn0, 1);
        check(last_result == 3'd3, "R2", "not-ready result", last_result, 3);
        repeat (3) nclk();
        check(datacmds == d0 && rxcnt == r0 && !busy, "R2", "no command or word after refusal", datacmds - d0, 0);
        card_ready = 1'b1;
    endtask

    task automatic test_cmd_fail();
        int dn0 = done_cnt, r0 = rxcnt, s0 = stops;
        cmd_ok     = 1'b0;
        line_limit = stops;
        dir_write  = 1'b0;
        sector     = 32'd9;
        start      = 1'b1;
        nclk();
        start = 1'b0;
        wait_done(dn0);
        check(last_result == 3'd1, "R4", "failed data command result", last_result, 1);
        check(rxcnt == r0 && stops == s0, "R4", "words moved after failed command", rxcnt - r0, 0);
        cmd_ok = 1'b1;
        nclk();
    endtask

    // one block; err_at < 0 means no error
    task automatic run_block(input bit wr, input logic [31:0] sec, input bit hc, input int err_at,
                             input int err_kind, input int stop_n, input int exp_stops,
                             input int exp_res, input string tag);
        int m0 = moved(wr), d0 = datacmds, s0 = stops, e0 = errclr_cnt, dn0 = done_cnt, f0 = fin_cnt;
        int t;
        logic [31:0] exp_arg = hc ? sec : (sec << 9);
        line_limit = stops + stop_n;
        sector    = sec;
        high_cap  = hc;
        dir_write = wr;
        start     = 1'b1;
        nclk();
        start = 1'b0;
        t = 0;
        while (datacmds == d0 && t < 50) begin
            nclk();
            t++;
        end
        check(last_arg == exp_arg, "R3", "data command argument", int'(last_arg), int'(exp_arg));
        check(last_kind == {1'b0, wr}, "R3", "data command kind", last_kind, int'(wr));
        for (int b = 0; b < BURSTS; b++) begin
            if (b == err_at) begin
                if (err_kind == 0) err_endbit = 1'b1;
                else if (err_kind == 1) err_crc = 1'b1;
                else err_tmo = 1'b1;
                if (wr) buf_wr_rdy = 1'b1;
                else    buf_rd_rdy = 1'b1;
                break;
            end
            repeat (3) nclk();
            check(moved(wr) - m0 == b * WORDS, "R7", "words moved while flag low", moved(wr) - m0, b * WORDS);
            if (wr) buf_wr_rdy = 1'b1;
            else    buf_rd_rdy = 1'b1;
            t = 0;
            while (moved(wr) - m0 < (b + 1) * WORDS && t < 400) begin
                nclk();
                t++;
            end
            buf_rd_rdy = 1'b0;
            buf_wr_rdy = 1'b0;
        end
        if (err_at < 0) begin
            repeat (4) nclk();
            check(done_cnt == dn0, "R11", "done before transfer complete", done_cnt - dn0, 0);
            check(moved(wr) - m0 == BURSTS * WORDS, tag, "words in block", moved(wr) - m0, BURSTS * WORDS);
            xfer_done = 1'b1;
            nclk();
            xfer_done = 1'b0;
            check(done_cnt == dn0 + 1 && fin_cnt == f0 + 1, "R11", "done with fin_clr after completion",
                  fin_cnt - f0, 1);
            check(last_result == 3'd0, "R11", "completion result", last_result, 0);
        end else begin
            wait_done(dn0);
            err_endbit = 1'b0;
            err_crc    = 1'b0;
            err_tmo    = 1'b0;
            buf_rd_rdy = 1'b0;
            buf_wr_rdy = 1'b0;
            check(errclr_cnt == e0 + 1, "R8", "error clear pulses", errclr_cnt - e0, 1);
            check(moved(wr) - m0 == err_at * WORDS, "R8", "words moved before abort", moved(wr) - m0, err_at * WORDS);
            check(stops - s0 == exp_stops, exp_res == 5 ? "R10" : "R9", "stop commands", stops - s0, exp_stops);
            check(last_result == 3'(exp_res), exp_res == 5 ? "R10" : "R9", "abort result", last_result, exp_res);
        end
        nclk();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nclk();
        test_reset();
        test_not_ready();
        run_block(1'b0, 32'd5,      1'b0, -1, 0, 0,    0,          0, "R5");
        run_block(1'b1, 32'h1234,   1'b1, -1, 0, 0,    0,          0, "R6");
        run_block(1'b0, 32'd40,     1'b0,  3, 1, 3,    3,          1, "R8");
        run_block(1'b1, 32'd2,      1'b1,  0, 0, 1000, STOP_TRIES, 5, "R8");
        test_cmd_fail();
        run_block(1'b0, 32'd7,      1'b1, -1, 2, 0,    0,          0, "R12");
        run_block(1'b1, 32'd3,      1'b0,  5, 2, 1,    1,          1, "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

endmodule